// File: doc/BRIEF.md
# Coherency Unit Register Block

This block is the small register window of a multicore cluster's coherency control unit. It decodes a 256-byte byte-offset space on a simple register bus: one strobe, a write flag, an address, write data and registered read data. One location holds the unit's enable bit, which is also driven out to the cluster. A second location returns a configuration word that the block computes from its core-count parameter.

Several locations only exist so that software which touches them behaves. These are power status, secure invalidate-all, the address filter bounds and the access permissions. Reads of them return zero and writes to them change nothing. The same holds for every offset that is not named.

The core count is an elaboration parameter from 1 to 4. Read data appears one clock after the read strobe and is held until the next read.

Top module: `coh_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears the enable bit and the read data register to zero.
- R2: A write strobe (req_valid=1, req_write=1) at offset 0x00 stores bit 0 of the write data. coh_enable shows the stored value from the next clock. The other bits of the write data are discarded.
- R3: A read at offset 0x00 returns the stored enable bit in bit 0, with bits 31:1 zero.
- R4: A read at offset 0x04 returns the configuration word. Bits 7:4 hold a presence mask of (2^N)-1 and bits 1:0 hold N-1, where N is the core count. All other bits are zero (0x72 for N=3).
- R5: Offset 0x04 is read-only. A write there leaves both the enable bit and the configuration word unchanged.
- R6: Offsets 0x08 (power status), 0x0C (secure invalidate-all), 0x40 and 0x44 (filter bounds), and 0x50 and 0x54 (access permissions) read as zero. Writes to any of them leave the enable bit unchanged.
- R7: Every other offset, including misaligned ones such as 0x01, reads as zero and ignores writes.
- R8: Read data is registered. rsp_rdata takes its new value at the clock edge that samples a read strobe (req_valid=1, req_write=0). It holds that value through idle cycles and write cycles.
- R9: The core count must lie in 1..4, and a value outside that range stops elaboration. Inside the range, the field in bits 1:0 and the mask in bits 7:4 agree with the parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| coh_enable | output | 1 | Stored enable bit |

## Verification
The bench targets three kinds of corner case. Writes of all-ones patterns to read-only and dead offsets would flip the enable bit in a design whose decode aliases those offsets onto 0x00. A misaligned offset that matches only in its upper bits would read a nonzero word in a decoder that drops the low address bits. Idle and write cycles between reads expose read data that tracks the address combinationally instead of holding. The bench also checks the configuration word for an off-by-one in the mask or in the count field. It checks that write data with only upper bits set leaves the enable bit at zero, which a design storing the wrong bit would fail. Finally, it checks that a reset in the middle of a run clears a set enable bit.

// File: rtl/coh_regs_pkg.sv
package coh_regs_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned MAX_CORES = 4;

    // Byte offsets inside the window
    localparam logic [7:0] OFF_CTRL     = 8'h00;
    localparam logic [7:0] OFF_CFG      = 8'h04;
    localparam logic [7:0] OFF_PWR      = 8'h08;
    localparam logic [7:0] OFF_INVAL    = 8'h0C;
    localparam logic [7:0] OFF_FILT_LO  = 8'h40;
    localparam logic [7:0] OFF_FILT_HI  = 8'h44;
    localparam logic [7:0] OFF_PERM     = 8'h50;
    localparam logic [7:0] OFF_PERM_NS  = 8'h54;

    typedef enum logic [3:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_PWR,
        SEL_INVAL,
        SEL_FILT_LO,
        SEL_FILT_HI,
        SEL_PERM,
        SEL_PERM_NS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Configuration word: presence mask in [7:4], count-1 in [1:0]
    function automatic logic [DATA_W-1:0] cfg_word(input int unsigned n);
        logic [DATA_W-1:0] w;
        logic [3:0]        mask;
        w    = '0;
        mask = 4'((1 << n) - 1);
        w[7:4] = mask;
        w[1:0] = 2'(n - 1);
        return w;
    endfunction

endpackage

// File: rtl/coh_addr_decode.sv
module coh_addr_decode
    import coh_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    reg_sel_e sel;

    always_comb begin
        if      (hit(addr, OFF_CTRL))    sel = SEL_CTRL;
        else if (hit(addr, OFF_CFG))     sel = SEL_CFG;
        else if (hit(addr, OFF_PWR))     sel = SEL_PWR;
        else if (hit(addr, OFF_INVAL))   sel = SEL_INVAL;
        else if (hit(addr, OFF_FILT_LO)) sel = SEL_FILT_LO;
        else if (hit(addr, OFF_FILT_HI)) sel = SEL_FILT_HI;
        else if (hit(addr, OFF_PERM))    sel = SEL_PERM;
        else if (hit(addr, OFF_PERM_NS)) sel = SEL_PERM_NS;
        else                             sel = SEL_NONE;
    end

    always_comb begin
        req.rd    = valid & ~write;
        req.wr    = valid & write;
        req.sel   = sel;
        req.wdata = wdata;
    end
endmodule

// File: rtl/coh_ctrl_reg.sv
module coh_ctrl_reg
    import coh_regs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     enable
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^req.wdata[DATA_W-1:1] ^ req.rd;

    logic take;
    assign take = req.wr && (req.sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst)       enable <= 1'b0;
        else if (take) enable <= req.wdata[0];
    end

    // Stored bit follows bit 0 of a control write
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == SEL_CTRL) |=> (enable == $past(req.wdata[0])));

    // Any access other than a control write leaves the bit alone
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_CTRL) |=> $stable(enable));
endmodule

// File: rtl/coh_rdata_reg.sv
module coh_rdata_reg
    import coh_regs_pkg::*;
#(
    parameter int unsigned NUM_CORES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              enable,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        unique case (req.sel)
            SEL_CTRL: rd_next = {{(DATA_W-1){1'b0}}, enable};
            SEL_CFG:  rd_next = CFG_VAL;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_next;
    end

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> $stable(rdata));

    assert_cfg_fields_R4: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_CFG) |=>
            (rdata[1:0] == 2'(NUM_CORES - 1)) && (rdata[DATA_W-1:8] == '0)
            && (rdata[3:2] == 2'b00));

    assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel == SEL_CTRL) |=>
            (rdata[DATA_W-1:1] == '0) && (rdata[0] == $past(enable)));

    assert_dead_read_R7: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.sel != SEL_CTRL && req.sel != SEL_CFG) |=> (rdata == '0));
endmodule

// File: rtl/coh_ctrl_regs.sv
module coh_ctrl_regs
    import coh_regs_pkg::*;
#(
    parameter int unsigned NUM_CORES = 1,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              coh_enable
);
    // R9: reject an unsupported core count while elaborating
    generate
        if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_core_count
            $error("coh_ctrl_regs: NUM_CORES must lie in 1..%0d", MAX_CORES);
        end
    endgenerate

    bus_req_t req;

    coh_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .wdata (req_wdata),
        .req   (req)
    );

    coh_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .enable (coh_enable)
    );

    coh_rdata_reg #(.NUM_CORES(NUM_CORES)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .enable (coh_enable),
        .rdata  (rsp_rdata)
    );

    // A write never disturbs the read data register
    assert_write_no_rdata_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> $stable(rsp_rdata));

    // Read-only configuration location does not reach the enable bit
    assert_cfg_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == ADDR_W'(OFF_CFG)) |=> $stable(coh_enable));
endmodule

// File: tb/sim_coh_ctrl_regs.sv
`timescale 1ns/1ps
module sim_coh_ctrl_regs;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        coh_enable;

    always #2 clk = ~clk;

    coh_ctrl_regs #(.NUM_CORES(N), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .coh_enable(coh_enable)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 0;

    // Behavioural reference state
    bit          m_en = 0;
    logic [31:0] m_rd = 0;
    logic [31:0] cfg_exp;

    initial cfg_exp = (((32'd1 << N) - 1) << 4) | (N - 1);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Reference update after each edge
    always @(posedge clk) begin
        if (rst) begin
            m_en = 0;
            m_rd = 0;
        end else if (req_valid && req_write) begin
            if (req_addr == 8'h00) m_en = req_wdata[0];
        end else if (req_valid) begin
            if (req_addr == 8'h00)      m_rd = {31'b0, m_en};
            else if (req_addr == 8'h04) m_rd = cfg_exp;
            else                        m_rd = 0;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check({cur_req, " rdata"}, rsp_rdata, m_rd);
            check({cur_req, " enable"}, {31'b0, coh_enable}, {31'b0, m_en});
        end
    end

    task automatic cyc(input string req, input bit v, input bit w,
                       input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cur_req   = req;
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic idle(input string req);
        cyc(req, 0, 0, 8'h00, 32'h0);
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        cyc(req, 1, 0, a, 32'h0);
    endtask

    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        cyc(req, 1, 1, a, d);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] dead [8] = '{8'h08, 8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'hFC};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset rdata", rsp_rdata, 32'h0);
        check("R1 reset enable", {31'b0, coh_enable}, 32'h0);
        @(negedge clk);
        rst = 0;
        idle("R1");

        // R4, R9: configuration word for N=3
        rd("R4", 8'h04);
        idle("R4");
        check("R4 cfg value", rsp_rdata, 32'h0000_0072);
        check("R9 core field", {30'b0, rsp_rdata[1:0]}, 32'(N - 1));
        check("R9 mask field", {28'b0, rsp_rdata[7:4]}, 32'((1 << N) - 1));

        // R2, R3: set and read the enable bit
        wr("R2", 8'h00, 32'h0000_0001);
        rd("R3", 8'h00);
        idle("R3");
        check("R3 ctrl read", rsp_rdata, 32'h1);
        check("R2 enable out", {31'b0, coh_enable}, 32'h1);

        // R2: only bit 0 kept
        wr("R2", 8'h00, 32'hFFFF_FFFE);
        rd("R3", 8'h00);
        idle("R2");
        check("R2 upper bits dropped", rsp_rdata, 32'h0);
        wr("R2", 8'h00, 32'hFFFF_FFFF);
        rd("R3", 8'h00);
        idle("R3");
        check("R3 ctrl read ones", rsp_rdata, 32'h1);

        // R5: write to read-only configuration
        wr("R5", 8'h04, 32'h0000_0000);
        rd("R5", 8'h04);
        idle("R5");
        check("R5 cfg unchanged", rsp_rdata, 32'h72);
        check("R5 enable unchanged", {31'b0, coh_enable}, 32'h1);

        // R6, R7: dead offsets, with enable at 1 then at 0
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 8; i++) begin
                string tag;
                tag = (i < 6) ? "R6" : "R7";
                wr(tag, dead[i], pass == 0 ? 32'h0 : 32'hFFFF_FFFF);
                rd(tag, dead[i]);
                idle(tag);
                check({tag, " dead read"}, rsp_rdata, 32'h0);
                check({tag, " dead write"}, {31'b0, coh_enable}, {31'b0, pass == 0});
            end
            wr("R2", 8'h00, 32'h0);
        end

        // R8: hold through idle and write cycles
        rd("R8", 8'h04);
        idle("R8");
        wr("R8", 8'h00, 32'h1);
        wr("R8", 8'h44, 32'h5);
        idle("R8");
        check("R8 held", rsp_rdata, 32'h72);
        rd("R8", 8'h00);
        idle("R8");
        check("R8 new read", rsp_rdata, 32'h1);

        // R1: reset mid-run clears the bit
        @(negedge clk);
        rst = 1;
        idle("R1");
        idle("R1");
        check("R1 mid-run enable", {31'b0, coh_enable}, 32'h0);
        check("R1 mid-run rdata", rsp_rdata, 32'h0);
        rst = 0;
        rd("R3", 8'h00);
        idle("R3");
        check("R3 after reset", rsp_rdata, 32'h0);

        @(negedge clk);
        finish_run();
    end
endmodule